// File: doc/BRIEF.md
# Four-Channel Rate-to-Pulse Generator

This block converts 32-bit rate words into trains of fixed-width pulses on four outputs, numbered 0 (W), 1 (R), 2 and 3. Every channel keeps a fractional phase accumulator. On each update tick the channel's active rate is added to that accumulator. Each overflow emits one pulse and the remainder is carried forward, so the long-term pulse frequency is exactly rate / 2^FRAC_W pulses per tick. Peak timing error is one tick and average error is zero. Channels 0 and 1 update on every multiplexer frame tick. Channels 2 and 3 update on every fourth tick, so their timing error is four times larger.

Each channel picks its rate from one of three kinds of source: an internal engine sum, a host-written register, or one of several post-processed sums. The active rate changes only at an accumulation-interval strobe, and the delay before a new value is used depends on its source. Host writes go into a staging register first, and the active rate copies that register at the strobe. A rate too large to reach is clamped to one pulse per tick instead of wrapping.

Top module: `rate_pulse_gen`

## Requirements
- R1: A synchronous reset drives all pulse outputs low and clears every active rate, staging register, source code, delay register and accumulator. After reset, ticks with no interval strobe produce no pulses.
- R2: For a channel with active rate r < 2^FRAC_W, each update tick adds r to the accumulator. When the sum reaches 2^FRAC_W, one pulse is emitted and 2^FRAC_W is subtracted. After N update ticks from a cleared accumulator, the pulse count is floor(N·r / 2^FRAC_W).
- R3: Channels 0 and 1 update on every frame tick. Channels 2 and 3 update only on the 4th, 8th, 12th, … frame tick after reset.
- R4: A channel whose active rate is ≥ 2^FRAC_W emits one pulse on every update tick and leaves its accumulator unchanged. It never wraps to a lower rate.
- R5: Source codes: 0 to NPP-1 select post-processed sum k, which is the 32-bit slice k of `pp_sums`. Code 35 selects the internal sum, which is `ce_w_sum` for channel 0 and `ce_r_sum` for channel 1. Code 36 selects the host staging register. Every other code, and code 35 on channels 2 and 3, selects a rate of zero.
- R6: An internal or host value present at an interval strobe becomes active at that strobe. A post-processed value sampled at strobe k becomes active at strobe k+1.
- R7: A host write never changes an active rate between strobes. A write made in the same cycle as a strobe lands in staging, and the strobe loads the previous staging value.
- R8: When a frame tick and an interval strobe fall in the same cycle, the accumulation for that tick uses the rate that was active before the strobe.
- R9: A pulse is high for exactly PULSE_W clocks, starting in the cycle after the update tick. A pulse request that arrives while a pulse is high is held in a single slot. That held request starts after exactly one low cycle, and a further request arriving while the slot is full is dropped.
- R10: The register interface uses `wr_addr` bit 2 to choose the target. With bit 2 = 0, address k writes the host staging value of channel k. With bit 2 = 1, address 4+k writes the source code of channel k from `wr_data[5:0]`. A source change takes effect at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle multiplexer frame tick |
| intv_strobe | input | 1 | One-cycle accumulation-interval boundary |
| ce_w_sum | input | 32 | Internal engine sum for channel 0 |
| ce_r_sum | input | 32 | Internal engine sum for channel 1 |
| pp_sums | input | NPP·32 | Post-processed sums, slice k is sum k |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address (see R10) |
| wr_data | input | 32 | Register write data |
| pulse_out | output | 4 | Pulse outputs, bit c is channel c |

## Verification
Two pairs of events can land in the same clock cycle, and both pairs are driven on purpose. The first pair is a frame tick together with an interval strobe. A directed case drops the staging value from full scale to zero and then strobes on a tick, so exactly one extra pulse must appear. The random intervals also put a tick on the strobe cycle about half of the time. The second pair is a host write together with a strobe. Here the active rate must take the old staging value. Both pairs are judged by cumulative rising-edge counts per channel, compared against a bench model that applies each cycle's accumulation with the pre-strobe rate.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  localparam int NUM_CH   = 4;
  localparam int FAST_CH  = 2;
  localparam int ADDR_W   = $clog2(NUM_CH) + 1;
  localparam int SRC_W    = 6;
  localparam logic [SRC_W-1:0] SRC_INT  = 6'd35;
  localparam logic [SRC_W-1:0] SRC_HOST = 6'd36;
endpackage

// File: rtl/rpg_src_mux.sv
module rpg_src_mux
  import rpg_pkg::*;
#(
  parameter int RATE_W  = 32,
  parameter int NPP     = 5,
  parameter bit HAS_INT = 1'b1
) (
  input  logic [SRC_W-1:0]      src,
  input  logic [RATE_W-1:0]     int_val,
  input  logic [RATE_W-1:0]     host_val,
  input  logic [NPP*RATE_W-1:0] pp_vals,
  output logic [RATE_W-1:0]     rate
);
  always_comb begin
    rate = '0;
    if (src == SRC_INT) begin
      rate = HAS_INT ? int_val : '0;
    end else if (src == SRC_HOST) begin
      rate = host_val;
    end else begin
      for (int i = 0; i < NPP; i++) begin
        if (src == SRC_W'(i)) rate = pp_vals[i*RATE_W +: RATE_W];
      end
    end
  end
endmodule

// File: rtl/rpg_accum.sv
module rpg_accum #(
  parameter int RATE_W = 32,
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [RATE_W-1:0] rate,
  output logic              fire
);
  localparam logic [RATE_W:0] FULL = (RATE_W+1)'(1) << FRAC_W;

  logic [FRAC_W-1:0] acc;
  logic [RATE_W:0]   sum;
  logic              sat;
  logic              over;

  assign sat  = {1'b0, rate} >= FULL;
  assign sum  = (RATE_W+1)'(acc) + {1'b0, rate};
  assign over = sum >= FULL;
  assign fire = upd && (sat || over);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (upd && !sat) begin
      acc <= over ? FRAC_W'(sum - FULL) : FRAC_W'(sum);
    end
  end
endmodule

// File: rtl/rpg_shaper.sv
module rpg_shaper #(
  parameter int PULSE_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic pulse
);
  localparam int CNT_W = $clog2(PULSE_W + 1);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic             pend, pend_n;

  always_comb begin
    cnt_n  = cnt;
    pend_n = pend;
    if (cnt != '0) begin
      cnt_n = cnt - 1'b1;
      if (req) pend_n = 1'b1;
    end else if (req || pend) begin
      cnt_n  = CNT_W'(PULSE_W);
      pend_n = pend && req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pend  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      pend  <= pend_n;
      pulse <= (cnt_n != '0);
    end
  end
endmodule

// File: rtl/rate_pulse_gen.sv
module rate_pulse_gen
  import rpg_pkg::*;
#(
  parameter int RATE_W   = 32,
  parameter int FRAC_W   = 24,
  parameter int NPP      = 5,
  parameter int PULSE_W  = 2,
  parameter int SLOW_DIV = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_tick,
  input  logic                  intv_strobe,
  input  logic [RATE_W-1:0]     ce_w_sum,
  input  logic [RATE_W-1:0]     ce_r_sum,
  input  logic [NPP*RATE_W-1:0] pp_sums,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [RATE_W-1:0]     wr_data,
  output logic [NUM_CH-1:0]     pulse_out
);
  localparam int SC_W = $clog2(SLOW_DIV);
  localparam int IX_W = ADDR_W - 1;

  logic [RATE_W-1:0]        host_stage [NUM_CH];
  logic [SRC_W-1:0]         src_q      [NUM_CH];
  logic [NPP*RATE_W-1:0]    pp_dly;
  logic [NUM_CH*RATE_W-1:0] rate_flat;
  logic [SC_W-1:0]          slow_cnt;
  logic                     slow_tick;

  // register interface: staging values and source codes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) begin
        host_stage[i] <= '0;
        src_q[i]      <= '0;
      end
    end else if (wr_en) begin
      if (!wr_addr[ADDR_W-1]) host_stage[wr_addr[IX_W-1:0]] <= wr_data;
      else                    src_q[wr_addr[IX_W-1:0]]      <= wr_data[SRC_W-1:0];
    end
  end

  // post-processed sums wait one extra interval
  always_ff @(posedge clk) begin
    if (rst)              pp_dly <= '0;
    else if (intv_strobe) pp_dly <= pp_sums;
  end

  // divided tick for the slow channels
  always_ff @(posedge clk) begin
    if (rst) slow_cnt <= '0;
    else if (frame_tick)
      slow_cnt <= (slow_cnt == SC_W'(SLOW_DIV-1)) ? '0 : slow_cnt + 1'b1;
  end
  assign slow_tick = frame_tick && (slow_cnt == SC_W'(SLOW_DIV-1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [RATE_W-1:0] int_val;
    logic [RATE_W-1:0] cand;
    logic [RATE_W-1:0] rate_q;
    logic              upd;
    logic              fire;

    if (c == 0) begin : g_iw
      assign int_val = ce_w_sum;
    end else if (c == 1) begin : g_ir
      assign int_val = ce_r_sum;
    end else begin : g_in
      assign int_val = '0;
    end

    rpg_src_mux #(.RATE_W(RATE_W), .NPP(NPP), .HAS_INT(c < FAST_CH)) u_mux (
      .src(src_q[c]), .int_val(int_val), .host_val(host_stage[c]),
      .pp_vals(pp_dly), .rate(cand)
    );

    always_ff @(posedge clk) begin
      if (rst)              rate_q <= '0;
      else if (intv_strobe) rate_q <= cand;
    end
    assign rate_flat[c*RATE_W +: RATE_W] = rate_q;

    if (c < FAST_CH) begin : g_fast
      assign upd = frame_tick;
    end else begin : g_slow
      assign upd = slow_tick;
    end

    rpg_accum #(.RATE_W(RATE_W), .FRAC_W(FRAC_W)) u_acc (
      .clk(clk), .rst(rst), .upd(upd), .rate(rate_q), .fire(fire)
    );

    rpg_shaper #(.PULSE_W(PULSE_W)) u_shp (
      .clk(clk), .rst(rst), .req(fire), .pulse(pulse_out[c])
    );
  end
endmodule

// File: rtl/rpg_chk.sv
module rpg_chk #(
  parameter int RATE_W = 32,
  parameter int FRAC_W = 24,
  parameter int NCH    = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  frame_tick,
  input logic                  intv_strobe,
  input logic [NCH-1:0]        pulse_out,
  input logic [NCH*RATE_W-1:0] rate_flat
);
  localparam logic [RATE_W:0] FULL = (RATE_W+1)'(1) << FRAC_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pulse_out == '0 && rate_flat == '0));

  // R7
  rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !intv_strobe |=> $stable(rate_flat));

  // R4
  sat_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && !pulse_out[0] && ({1'b0, rate_flat[RATE_W-1:0]} >= FULL))
    |=> pulse_out[0]);

  for (genvar k = 0; k < NCH; k++) begin : g_rise
    // R9
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_out[k]) |-> ($past(frame_tick) || $past(pulse_out[k], 2)));
  end
endmodule

bind rate_pulse_gen rpg_chk #(
  .RATE_W(RATE_W), .FRAC_W(FRAC_W), .NCH(rpg_pkg::NUM_CH)
) u_chk (
  .clk(clk), .rst(rst), .frame_tick(frame_tick), .intv_strobe(intv_strobe),
  .pulse_out(pulse_out), .rate_flat(rate_flat)
);

// File: tb/sim_rate_pulse_gen.sv
module sim_rate_pulse_gen;
  localparam int RW = 32;
  localparam int FW = 24;
  localparam int NPP = 5;
  localparam int PW = 2;
  localparam longint FULL = 64'd1 << FW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0;
  logic intv_strobe = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] ce_w = '0;
  logic [31:0] ce_r = '0;
  logic [NPP*32-1:0] pp = '0;
  logic [3:0] pulse_out;

  always #4 clk = ~clk;

  rate_pulse_gen #(.RATE_W(RW), .FRAC_W(FW), .NPP(NPP), .PULSE_W(PW), .SLOW_DIV(4)) u0 (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .intv_strobe(intv_strobe),
    .ce_w_sum(ce_w), .ce_r_sum(ce_r), .pp_sums(pp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pulse_out(pulse_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  longint      m_acc [4];
  longint      m_exp [4];
  logic [31:0] m_rate [4];
  logic [31:0] m_stage [4];
  logic [5:0]  m_src [4];
  logic [NPP*32-1:0] m_ppd;
  int          m_sc;
  int          obs [4];
  logic [3:0]  prev;

  always @(negedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) obs[k] = 0;
      prev = '0;
    end else begin
      for (int k = 0; k < 4; k++) if (pulse_out[k] && !prev[k]) obs[k]++;
      prev = pulse_out;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // source selection as stated in R5 (post-processed values through the R6 delay)
  function automatic logic [31:0] pick(input int k, input logic [5:0] s);
    if (s == 6'd35) return (k == 0) ? ce_w : (k == 1) ? ce_r : 32'd0;
    if (s == 6'd36) return m_stage[k];
    if (int'(s) < NPP) return m_ppd[int'(s)*32 +: 32];
    return 32'd0;
  endfunction

  task automatic model(input bit t, input bit s, input bit we, input logic [2:0] a,
                       input logic [31:0] d);
    logic [31:0] nr [4];
    for (int k = 0; k < 4; k++) nr[k] = pick(k, m_src[k]);
    if (t) begin
      for (int k = 0; k < 4; k++) begin
        if (k < 2 || m_sc == 3) begin
          if (longint'(m_rate[k]) >= FULL) m_exp[k]++;
          else begin
            m_acc[k] += longint'(m_rate[k]);
            if (m_acc[k] >= FULL) begin m_exp[k]++; m_acc[k] -= FULL; end
          end
        end
      end
      m_sc = (m_sc + 1) % 4;
    end
    if (s) begin
      for (int k = 0; k < 4; k++) m_rate[k] = nr[k];
      m_ppd = pp;
    end
    if (we) begin
      if (!a[2]) m_stage[a[1:0]] = d;
      else       m_src[a[1:0]]   = d[5:0];
    end
  endtask

  task automatic step(input bit t, input bit s, input bit we = 1'b0,
                      input logic [2:0] a = 3'd0, input logic [31:0] d = 32'd0);
    @(negedge clk);
    frame_tick = t; intv_strobe = s; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model(t, s, we, a, d);
  endtask

  task automatic idle(input int n);
    repeat (n) step(1'b0, 1'b0);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      step(1'b1, 1'b0);
      idle(5);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; frame_tick = 1'b0; intv_strobe = 1'b0; wr_en = 1'b0;
    ce_w = '0; ce_r = '0; pp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      m_acc[k] = 0; m_exp[k] = 0; m_rate[k] = '0; m_stage[k] = '0; m_src[k] = '0;
    end
    m_ppd = '0; m_sc = 0;
  endtask

  function automatic logic [31:0] rnd_rate();
    int r;
    r = int'($urandom % 20);
    if (r < 5)  return $urandom % (32'd1 << 20);
    if (r < 14) return $urandom % (32'd1 << FW);
    if (r < 17) return 32'd1 << FW;
    return $urandom | 32'h0100_0000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] codes [8];
    codes = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd35, 6'd36, 6'd50};
    void'($urandom(32'd7717));

    // R1: reset state, and no pulses without a strobe
    do_reset();
    chk(pulse_out == 4'd0, "R1 outputs after reset", pulse_out, 0);
    pp[31:0] = 32'(FULL);
    ticks(8);
    for (int k = 0; k < 4; k++) chk(obs[k] == 0, "R1 no pulses before strobe", obs[k], 0);

    // R4 saturation, R3 quarter rate, R5 internal code on a slow channel
    do_reset();
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'(FULL)); wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'(FULL));
    wr(3'd4, 32'd36); wr(3'd5, 32'd36); wr(3'd6, 32'd36); wr(3'd7, 32'd35);
    step(1'b0, 1'b1);
    ticks(16);
    chk(obs[0] == 16, "R4 channel 0 above full scale", obs[0], 16);
    chk(obs[1] == 16, "R4 channel 1 at full scale", obs[1], 16);
    chk(obs[2] == 4, "R3 channel 2 quarter rate", obs[2], 4);
    chk(obs[3] == 0, "R5 internal code on channel 3", obs[3], 0);

    // R6, R10: post-processed one interval later, internal at once
    do_reset();
    pp[31:0] = 32'(FULL); ce_r = 32'(FULL);
    wr(3'd5, 32'd35);
    step(1'b0, 1'b1);
    ticks(8);
    chk(obs[0] == 0, "R6 post-processed delayed", obs[0], 0);
    chk(obs[1] == 8, "R6 internal immediate", obs[1], 8);
    step(1'b0, 1'b1);
    ticks(8);
    chk(obs[0] == 8, "R6/R10 post-processed after second strobe", obs[0], 8);
    chk(obs[1] == 16, "R6 internal second interval", obs[1], 16);

    // R7: double buffering of host values
    do_reset();
    wr(3'd4, 32'd36); wr(3'd0, 32'(FULL));
    step(1'b0, 1'b1);
    ticks(4); wr(3'd0, 32'd0); ticks(4);
    chk(obs[0] == 8, "R7 mid-interval write ignored", obs[0], 8);
    step(1'b0, 1'b1, 1'b1, 3'd0, 32'(FULL));
    ticks(4);
    chk(obs[0] == 8, "R7 strobe takes old staging", obs[0], 8);
    step(1'b0, 1'b1);
    ticks(4);
    chk(obs[0] == 12, "R7 staging applied next strobe", obs[0], 12);

    // R8: tick and strobe in the same cycle
    do_reset();
    wr(3'd4, 32'd36); wr(3'd0, 32'(FULL));
    step(1'b0, 1'b1);
    ticks(2); wr(3'd0, 32'd0);
    step(1'b1, 1'b1); idle(5);
    ticks(3);
    chk(obs[0] == 3, "R8 coincident tick uses old rate", obs[0], 3);

    // R9: pulse width, held request, dropped extra request
    do_reset();
    wr(3'd4, 32'd36); wr(3'd0, 32'hFFFF_FFFF);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0); #1 chk(pulse_out[0] == 1'b1, "R9 pulse start", pulse_out[0], 1);
    step(1'b1, 1'b0); #1 chk(pulse_out[0] == 1'b1, "R9 pulse second cycle", pulse_out[0], 1);
    step(1'b1, 1'b0); #1 chk(pulse_out[0] == 1'b0, "R9 one low gap", pulse_out[0], 0);
    step(1'b0, 1'b0); #1 chk(pulse_out[0] == 1'b1, "R9 held pulse", pulse_out[0], 1);
    step(1'b0, 1'b0); #1 chk(pulse_out[0] == 1'b1, "R9 held pulse width", pulse_out[0], 1);
    step(1'b0, 1'b0); #1 chk(pulse_out[0] == 1'b0, "R9 held pulse end", pulse_out[0], 0);
    idle(3);
    chk(obs[0] == 2, "R9 one request held, one dropped", obs[0], 2);

    // random intervals against the bench model (R2 R3 R4 R5 R6 R7 R8 R10)
    do_reset();
    for (int it = 0; it < 12; it++) begin
      for (int k = 0; k < 4; k++) begin
        wr(3'(4 + k), 32'(codes[$urandom % 8]));
        wr(3'(k), rnd_rate());
      end
      for (int i = 0; i < NPP; i++) pp[i*32 +: 32] = rnd_rate();
      ce_w = rnd_rate(); ce_r = rnd_rate();
      step(1'($urandom % 2), 1'b1, 1'($urandom % 2), 3'($urandom % 4), rnd_rate());
      idle(5);
      ticks(15);
      wr(3'($urandom % 4), rnd_rate());
      ticks(15);
      idle(6);
      for (int k = 0; k < 4; k++)
        chk(longint'(obs[k]) == m_exp[k], "R2/R3/R4/R5/R6/R7/R8/R10 random interval count",
            obs[k], m_exp[k]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule